// File: doc/BRIEF.md
# Keyed Write-Once Watchdog

This block is a watchdog timer that runs off a free-running timebase counter clocked by the base clock. A two-bit interval code picks one of four timebase taps, whose periods are 2^(TAP_LOG2), 2^(TAP_LOG2+2), 2^(TAP_LOG2+4) and 2^(TAP_LOG2+6) base-clock cycles. With the default TAP_LOG2 of 20, these are 2^20, 2^22, 2^24 and 2^26. The first write to the control register after any reset latches the code and starts the watchdog. Software has no way to stop it afterwards.

A single detection bit is set by each rising transition of the selected tap. If a second transition arrives while the bit is still set, the block issues a reset pulse. Software holds the reset off by writing the key pair 0xA5 then 0x5A to the service register. A clear from the timebase also clears the detection bit. A sticky flag records that a watchdog reset took place.

Top module: `keyed_wdog`

## Requirements
- R1: After an external reset, `wdog_rst` is low. The control register reads 0x00, laid out as bit 7 = reset flag, bit 6 = running, bits 1:0 = interval code, other bits 0. The service register (addr 1) always reads 0x00.
- R2: Take a running watchdog with code c and let P = 2^(TAP_LOG2+2c). If the timebase is cleared at clock edge E and the block gets no service, `wdog_rst` first reads high after edge E + 3P/2 + 1.
- R3: The first control write (addr 0) after any reset latches bits 1:0 as the interval code and sets the running bit. Later control writes leave the code unchanged, both in readback and in timeout.
- R4: No register write stops a running watchdog. A stopped watchdog never raises `wdog_rst`. An external reset returns the block to the stopped state.
- R5: Two consecutive service writes, 0xA5 followed by 0x5A, clear the detection bit at the 0x5A write. Service given after the first tap event therefore pushes the R2 timeout out by one period P, to E + 5P/2 + 1.
- R6: A service sequence does not clear the detection bit in these cases:
  - a value other than 0x5A follows 0xA5;
  - 0x5A arrives without a directly preceding 0xA5.
  
  A repeated 0xA5 re-arms the sequence, so 0xA5, 0xA5, 0x5A is a valid key.
- R7: `tb_clear` zeroes the timebase counter and clears the detection bit in the same cycle, which restarts the R2 timing from that edge.
- R8: `wdog_rst` stays high for exactly RST_PULSE cycles. Register writes have no effect during the pulse. Afterwards the block is stopped with code 0, and the next control write is accepted as a first write.
- R9: A watchdog reset sets the flag (control bit 7), and the flag survives that reset. Writing 1 to control bit 7 clears the flag, and so does an external reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | External active-low reset, asynchronous assert |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 control, 1 service |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| tb_clear | input | 1 | Timebase clear request |
| wdog_rst | output | 1 | Watchdog reset pulse |

## Verification
On every cycle, the assertions check the following:
- a reset pulse rises only from a running watchdog whose detection bit is set;
- the interval code stays frozen while the watchdog runs;
- a key hit or a timebase clear leaves the detection bit at zero;
- the pulse has the exact width and leaves the flag set.

Some properties are end-to-end cycle counts, and only the bench scenarios can show them:
- the exact timeout for each interval code;
- the one-period postponement from a valid key;
- that broken key sequences leave the timeout unchanged;
- that later control writes are ignored.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] KEY_ARM  = 8'hA5;
  localparam logic [7:0] KEY_FIRE = 8'h5A;

  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_SVC  = 1'b1
  } wdog_reg_e;

  typedef struct packed {
    logic       flag;
    logic       run;
    logic [3:0] rsv;
    logic [1:0] code;
  } wdog_ctrl_t;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/wdog_timebase.sv
module wdog_timebase #(
  parameter int TB_WIDTH = 26,
  parameter int TAP_LOG2 = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic [1:0]          code,
  output logic                tap_ev,
  output logic [TB_WIDTH-1:0] cnt
);
  localparam int N_TAPS = 4;

  logic [TB_WIDTH-1:0] cnt_q, cnt_d;
  logic [N_TAPS-1:0]   ev;

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // a tap rises when its bit becomes 1 while all lower bits are 0
  for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
    localparam int K = TAP_LOG2 - 1 + 2 * i;
    localparam logic [K:0] PAT = {1'b1, {K{1'b0}}};
    assign ev[i] = (cnt_q[K:0] == PAT);
  end

  assign tap_ev = ev[code];
  assign cnt    = cnt_q;
endmodule

// File: rtl/wdog_keyseq.sv
module wdog_keyseq
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       svc_wr,
  input  logic [7:0] data,
  output logic       key_hit
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    if (clr)         armed_d = 1'b0;
    else if (svc_wr) armed_d = (data == KEY_ARM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign key_hit = svc_wr && armed_q && (data == KEY_FIRE) && !clr;
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int RST_PULSE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_data,
  input  logic       tap_ev,
  input  logic       svc_clr,
  output logic [1:0] code,
  output logic       started,
  output logic       det,
  output logic       flag,
  output logic       pulse
);
  localparam int PW = $clog2(RST_PULSE + 1);

  logic [1:0]    code_q, code_d;
  logic          run_q, run_d;
  logic          det_q, det_d;
  logic          flag_q, flag_d;
  logic          pulse_q, pulse_d;
  logic [PW-1:0] pcnt_q, pcnt_d;

  always_comb begin
    code_d  = code_q;
    run_d   = run_q;
    det_d   = det_q;
    flag_d  = flag_q;
    pulse_d = pulse_q;
    pcnt_d  = pcnt_q;
    if (pulse_q) begin
      if (pcnt_q == '0) pulse_d = 1'b0;
      else              pcnt_d  = pcnt_q - 1'b1;
    end else begin
      if (cfg_wr && cfg_data[7]) flag_d = 1'b0;
      if (cfg_wr && !run_q) begin
        code_d = cfg_data[1:0];
        run_d  = 1'b1;
      end
      if (svc_clr) begin
        det_d = 1'b0;
      end else if (run_q && tap_ev) begin
        if (det_q) begin
          pulse_d = 1'b1;
          pcnt_d  = PW'(RST_PULSE - 1);
          flag_d  = 1'b1;
          run_d   = 1'b0;
          det_d   = 1'b0;
          code_d  = 2'b00;
        end else begin
          det_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= 2'b00;
      run_q   <= 1'b0;
      det_q   <= 1'b0;
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
      pcnt_q  <= '0;
    end else begin
      code_q  <= code_d;
      run_q   <= run_d;
      det_q   <= det_d;
      flag_q  <= flag_d;
      pulse_q <= pulse_d;
      pcnt_q  <= pcnt_d;
    end
  end

  assign code    = code_q;
  assign started = run_q;
  assign det     = det_q;
  assign flag    = flag_q;
  assign pulse   = pulse_q;
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import wdog_pkg::*;
#(
  parameter int TB_WIDTH  = 26,
  parameter int TAP_LOG2  = 20,
  parameter int RST_PULSE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       tb_clear,
  output logic       wdog_rst
);
  logic                rst_sync_n;
  logic                cfg_wr, svc_wr;
  logic                key_hit, svc_clr;
  logic                tap_ev;
  logic [TB_WIDTH-1:0] tb_cnt;
  logic [1:0]          code_w;
  logic                run_w, det_w, flag_w, pulse_w;
  wdog_ctrl_t          ctrl_rd;

  assign cfg_wr  = wr_en && (wdog_reg_e'(addr) == REG_CTRL);
  assign svc_wr  = wr_en && (wdog_reg_e'(addr) == REG_SVC);
  assign svc_clr = key_hit || tb_clear;

  wdog_rst_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wdog_timebase #(.TB_WIDTH(TB_WIDTH), .TAP_LOG2(TAP_LOG2)) u_tb (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr    (tb_clear || pulse_w),
    .code   (code_w),
    .tap_ev (tap_ev),
    .cnt    (tb_cnt)
  );

  wdog_keyseq u_key (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (pulse_w),
    .svc_wr  (svc_wr),
    .data    (wdata),
    .key_hit (key_hit)
  );

  wdog_core #(.RST_PULSE(RST_PULSE)) u_core (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cfg_wr   (cfg_wr),
    .cfg_data (wdata),
    .tap_ev   (tap_ev),
    .svc_clr  (svc_clr),
    .code     (code_w),
    .started  (run_w),
    .det      (det_w),
    .flag     (flag_w),
    .pulse    (pulse_w)
  );

  always_comb begin
    ctrl_rd      = '0;
    ctrl_rd.flag = flag_w;
    ctrl_rd.run  = run_w;
    ctrl_rd.code = code_w;
    rdata = (wdog_reg_e'(addr) == REG_CTRL) ? ctrl_rd : 8'h00;
  end

  assign wdog_rst = pulse_w;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int TB_WIDTH  = 26,
  parameter int RST_PULSE = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wdog_rst,
  input logic                started,
  input logic                det,
  input logic [1:0]          code,
  input logic                flag,
  input logic                key_hit,
  input logic                tb_clear,
  input logic                cfg_wr,
  input logic                cfg_bit7,
  input logic [TB_WIDTH-1:0] tb_cnt
);
  localparam int HW = $clog2(RST_PULSE + 1) + 1;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_cnt <= '0;
    else if (wdog_rst) hi_cnt <= hi_cnt + 1'b1;
    else               hi_cnt <= '0;
  end

  assert_stopped_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdog_rst) |-> $past(started));
  assert_fire_after_det_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdog_rst) |-> $past(det));
  assert_code_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(started)) |-> $stable(code));
  assert_key_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |=> !det);
  assert_tb_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tb_clear |=> (tb_cnt == '0 && !det));
  assert_pulse_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |-> (int'(hi_cnt) < RST_PULSE));
  assert_pulse_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdog_rst) |-> (int'(hi_cnt) == RST_PULSE && !started));
  assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdog_rst) |-> flag);
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(cfg_wr && cfg_bit7)) |=> flag);
endmodule

bind keyed_wdog wdog_chk #(.TB_WIDTH(TB_WIDTH), .RST_PULSE(RST_PULSE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .wdog_rst (wdog_rst),
  .started  (run_w),
  .det      (det_w),
  .code     (code_w),
  .flag     (flag_w),
  .key_hit  (key_hit),
  .tb_clear (tb_clear),
  .cfg_wr   (cfg_wr),
  .cfg_bit7 (wdata[7]),
  .tb_cnt   (tb_cnt)
);

// File: tb/tb_keyed_wdog.sv
`timescale 1ns/1ps
module tb_keyed_wdog;
  localparam int TB_WIDTH  = 9;
  localparam int TAP_LOG2  = 3;
  localparam int RST_PULSE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       tb_clear = 1'b0;
  logic       wdog_rst;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;

  keyed_wdog #(.TB_WIDTH(TB_WIDTH), .TAP_LOG2(TAP_LOG2), .RST_PULSE(RST_PULSE)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tb_clear(tb_clear), .wdog_rst(wdog_rst)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int period(int c);
    return 1 << (TAP_LOG2 + 2 * c);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; tb_clear = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(logic a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic a, output int v);
    addr = a; #1; v = int'(rdata);
  endtask

  task automatic clear_tb(output int e0);
    tb_clear = 1'b1; e0 = cyc + 1;
    @(negedge clk);
    tb_clear = 1'b0;
  endtask

  task automatic wait_fire(int cap, output int e1);
    e1 = -1;
    for (int n = 0; n < cap; n++) begin
      if (wdog_rst) begin e1 = cyc; break; end
      @(negedge clk);
    end
  endtask

  task automatic pulse_width(output int w);
    w = 0;
    while (wdog_rst && w < 100) begin w++; @(negedge clk); end
  endtask

  task automatic key_case(string tag, int n, logic [7:0] b0, logic [7:0] b1,
                          logic [7:0] b2, int exp);
    int e0, e1;
    logic [7:0] seq [3];
    seq[0] = b0; seq[1] = b1; seq[2] = b2;
    do_reset();
    wr(1'b0, 8'h01);
    clear_tb(e0);
    while (cyc < e0 + 20) @(negedge clk);
    for (int i = 0; i < n; i++) wr(1'b1, seq[i]);
    wait_fire(400, e1);
    check(tag, e1 - e0, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v, e0, e1, w, hit;
    do_reset();
    // R1: reset state and register map
    check("R1 wdog_rst after reset", int'(wdog_rst), 0);
    rd(1'b0, v); check("R1 ctrl readback", v, 8'h00);
    rd(1'b1, v); check("R1 svc readback", v, 8'h00);

    // R4: stopped never fires, service writes do not start it
    wr(1'b1, 8'hA5); wr(1'b1, 8'h5A);
    clear_tb(e0);
    wait_fire(2000, e1);
    check("R4 stopped no fire", e1, -1);
    rd(1'b0, v); check("R4 service does not start", v, 8'h00);

    // R2 + R8: sweep all interval codes
    for (int c = 0; c < 4; c++) begin
      do_reset();
      wr(1'b0, 8'(c));
      rd(1'b0, v); check("R3 start readback", v, 8'h40 | c);
      clear_tb(e0);
      wait_fire(3000, e1);
      check($sformatf("R2 timeout code %0d", c), e1 - e0, 3 * period(c) / 2 + 1);
      pulse_width(w);
      check("R8 pulse width", w, RST_PULSE);
      rd(1'b0, v); check("R9 flag after wd reset", v, 8'h80);
    end

    // R3: later control writes ignored; R8 next write accepted after pulse
    do_reset();
    wr(1'b0, 8'h01); wr(1'b0, 8'h03);
    rd(1'b0, v); check("R3 code locked readback", v, 8'h41);
    clear_tb(e0);
    wait_fire(3000, e1);
    check("R3 timeout uses first code", e1 - e0, 3 * period(1) / 2 + 1);
    pulse_width(w);
    wr(1'b0, 8'h02);
    rd(1'b0, v); check("R8 first write after wd reset", v, 8'hC2);
    clear_tb(e0);
    wait_fire(3000, e1);
    check("R8 new code timeout", e1 - e0, 3 * period(2) / 2 + 1);
    pulse_width(w);
    // R9: write-one clears flag (and starts with code 0)
    wr(1'b0, 8'h80);
    rd(1'b0, v); check("R9 flag W1C", v, 8'h40);
    // R4: external reset stops, clears flag
    do_reset();
    rd(1'b0, v); check("R4 ext reset stops", v, 8'h00);
    clear_tb(e0);
    wait_fire(600, e1);
    check("R4 no fire after ext reset", e1, -1);

    // R4: writes cannot stop a running watchdog
    do_reset();
    wr(1'b0, 8'h00);
    clear_tb(e0);
    wr(1'b0, 8'h00); wr(1'b1, 8'h00); wr(1'b0, 8'h83);
    wait_fire(3000, e1);
    check("R4 no software stop", e1 - e0, 3 * period(0) / 2 + 1);

    // R5 / R6: key sequences with code 1
    key_case("R5 valid key postpones", 2, 8'hA5, 8'h5A, 8'h00, 5 * period(1) / 2 + 1);
    key_case("R6 broken key A5 00 5A", 3, 8'hA5, 8'h00, 8'h5A, 3 * period(1) / 2 + 1);
    key_case("R6 lone 5A ignored", 1, 8'h5A, 8'h00, 8'h00, 3 * period(1) / 2 + 1);
    key_case("R6 rearm A5 A5 5A", 3, 8'hA5, 8'hA5, 8'h5A, 5 * period(1) / 2 + 1);

    // R7: timebase clear restarts the timing
    do_reset();
    wr(1'b0, 8'h01);
    clear_tb(e0);
    while (cyc < e0 + 25) @(negedge clk);
    clear_tb(e0);
    wait_fire(3000, e1);
    check("R7 tb_clear restarts", e1 - e0, 3 * period(1) / 2 + 1);

    // R5: periodic service keeps the reset away
    do_reset();
    wr(1'b0, 8'h00);
    clear_tb(e0);
    hit = 0;
    for (int k = 0; k < 30; k++) begin
      for (int j = 0; j < 4; j++) begin
        if (wdog_rst) hit = 1;
        @(negedge clk);
      end
      wr(1'b1, 8'hA5);
      if (wdog_rst) hit = 1;
      wr(1'b1, 8'h5A);
      if (wdog_rst) hit = 1;
    end
    check("R5 serviced no reset", hit, 0);
    wait_fire(2 * period(0) + 2, e1);
    check("R5 fires once service stops", int'(e1 != -1), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule